// File: doc/BRIEF.md
# Load-Reserved Reservation Monitor for Shared Memory

This block keeps the load-reserved / store-conditional reservations for a small group of harts that share one memory. Each hart can issue one request per cycle: a load-reserved, a store-conditional or an ordinary store, each with an address. The monitor holds at most one reservation per hart, matched on a 64-byte granule. It answers every store-conditional with a pass/fail code. It answers every load-reserved with a flag that says whether the line may be taken with exclusive permission; otherwise it must be fetched shared.

Reservations are removed only in ways that cannot livelock. A load-reserved never touches another hart's reservation. Other harts lose a matching reservation only to an ordinary store, or to a store-conditional in the same cycle in which that store-conditional is judged successful. External coherence invalidations clear matching reservations. When the hold window is enabled, an invalidation that hits a freshly reserved granule is stalled for a programmed number of cycles, so that a conforming sequence can reach its store-conditional first.

Top module: `rm_resv_monitor`

## Requirements
- R1: A load-reserved (op code 2'b01) sets the issuing hart's reservation on the request's granule and replaces any earlier reservation held by that hart.
- R2: A load-reserved never clears or alters a reservation held by another hart.
- R3: A store-conditional (op code 2'b10) succeeds only when the issuing hart holds a valid reservation on the same granule (address bits [5:0] ignored). resp_fail is 0 on success and 1 on failure. Op code 2'b00 is idle and gives no response.
- R4: A successful store-conditional clears every other hart's reservation on its granule in the same cycle in which it is judged.
- R5: A failing store-conditional leaves all other harts' reservations unchanged.
- R6: A store-conditional always clears the issuing hart's own reservation, pass or fail.
- R7: An ordinary store (op code 2'b11) clears other harts' reservations on its granule and keeps the issuer's own reservation.
- R8: Requests issued in the same cycle are applied in hart-index order, lowest first, and each request sees the state left by the lower-indexed ones.
- R9: resp_excl is 1 for a load-reserved only when no other hart holds a reservation on that granule at the moment the request is applied. It is 0 for every other response.
- R10: With hold_en set, inval_stall is high while inval_valid targets a granule that some hart has reserved and whose hold counter is nonzero. Each load-reserved loads its hart's counter with hold_cycles, and the counter then drops by one per cycle. With hold_en clear, no invalidation is stalled.
- R11: An accepted invalidation (inval_valid high and inval_stall low) clears every reservation on its granule, and it is applied before the same cycle's hart requests. Reservations on other granules are kept.
- R12: After reset no hart holds a reservation and all outputs are 0. Responses appear exactly one cycle after their request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | 2*NUM_HARTS | Per-hart op code, hart h at bits [2h+1:2h]: 00 idle, 01 load-reserved, 10 store-conditional, 11 store |
| req_addr | input | NUM_HARTS*ADDR_W | Per-hart byte address, hart h at bits [h*ADDR_W +: ADDR_W] |
| hold_en | input | 1 | Enables the invalidation hold window |
| hold_cycles | input | HOLD_W | Hold length loaded on each load-reserved |
| inval_valid | input | 1 | Incoming coherence invalidation present |
| inval_addr | input | ADDR_W | Address of the invalidated line |
| inval_stall | output | 1 | Invalidation is held this cycle and is not accepted |
| resp_valid | output | NUM_HARTS | Response present for a load-reserved or store-conditional issued the cycle before |
| resp_fail | output | NUM_HARTS | Store-conditional result code, 1 means failure |
| resp_excl | output | NUM_HARTS | Load-reserved may take the line exclusive |

## Verification
A reservation bit that is wrongly set or wrongly cleared has no output of its own. It becomes visible only at the owning hart's next store-conditional, which then passes or fails against expectation one cycle after issue. A bad reservation also shows up earlier through the exclusive flag of any other hart's load-reserved to the same granule, and through inval_stall in the same cycle as an invalidation to that granule. The stimulus therefore ends each scenario with store-conditionals and same-granule load-reserveds, including same-cycle collisions between harts. This turns hidden state errors into port mismatches within a cycle or two.

// File: rtl/rm_pkg.sv
package rm_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_LR    = 2'b01,
        OP_SC    = 2'b10,
        OP_STORE = 2'b11
    } rm_op_e;

    // Granule index of a byte address: drop the offset bits below the granule.
    function automatic logic [63:0] gran_index(input logic [63:0] addr, input int unsigned lg);
        return addr >> lg;
    endfunction

endpackage

// File: rtl/rm_hold_timer.sv
module rm_hold_timer #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [HOLD_W-1:0] load_val,
    output logic              busy
);
    logic [HOLD_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/rm_inval_gate.sv
module rm_inval_gate #(
    parameter int NUM_HARTS = 4,
    parameter int GRAN_W    = 26
) (
    input  logic [NUM_HARTS-1:0]             vld,
    input  logic [NUM_HARTS-1:0][GRAN_W-1:0] gran,
    input  logic [NUM_HARTS-1:0]             busy,
    input  logic                             hold_en,
    input  logic                             inval_valid,
    input  logic [GRAN_W-1:0]                inval_gran,
    output logic                             stall,
    output logic                             take
);
    logic [NUM_HARTS-1:0] held;

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_held
        assign held[h] = vld[h] && busy[h] && (gran[h] == inval_gran);
    end

    assign stall = inval_valid && hold_en && (|held);
    assign take  = inval_valid && !stall;
endmodule

// File: rtl/rm_resv_chain.sv
module rm_resv_chain
    import rm_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int GRAN_W    = 26
) (
    input  logic [NUM_HARTS-1:0]             vld_i,
    input  logic [NUM_HARTS-1:0][GRAN_W-1:0] gran_i,
    input  logic [NUM_HARTS-1:0][1:0]        op_i,
    input  logic [NUM_HARTS-1:0][GRAN_W-1:0] req_gran_i,
    input  logic                             inval_take_i,
    input  logic [GRAN_W-1:0]                inval_gran_i,
    output logic [NUM_HARTS-1:0]             vld_o,
    output logic [NUM_HARTS-1:0][GRAN_W-1:0] gran_o,
    output logic [NUM_HARTS-1:0]             lr_set_o,
    output logic [NUM_HARTS-1:0]             rsp_o,
    output logic [NUM_HARTS-1:0]             fail_o,
    output logic [NUM_HARTS-1:0]             excl_o
);
    always_comb begin
        logic [NUM_HARTS-1:0]             v;
        logic [NUM_HARTS-1:0][GRAN_W-1:0] g;
        logic                             other;
        logic                             hit;

        v        = vld_i;
        g        = gran_i;
        lr_set_o = '0;
        rsp_o    = '0;
        fail_o   = '0;
        excl_o   = '0;
        other    = 1'b0;
        hit      = 1'b0;

        // Accepted invalidation lands first, before any hart request.
        if (inval_take_i) begin
            for (int k = 0; k < NUM_HARTS; k++) begin
                if (v[k] && (g[k] == inval_gran_i)) v[k] = 1'b0;
            end
        end

        // Fixed priority: lower index applied first, later ones see its result.
        for (int h = 0; h < NUM_HARTS; h++) begin
            case (op_i[h])
                OP_LR: begin
                    other = 1'b0;
                    for (int k = 0; k < NUM_HARTS; k++) begin
                        if (k != h && v[k] && (g[k] == req_gran_i[h])) other = 1'b1;
                    end
                    excl_o[h]   = !other;
                    rsp_o[h]    = 1'b1;
                    lr_set_o[h] = 1'b1;
                    v[h]        = 1'b1;
                    g[h]        = req_gran_i[h];
                end
                OP_SC: begin
                    hit       = v[h] && (g[h] == req_gran_i[h]);
                    rsp_o[h]  = 1'b1;
                    fail_o[h] = !hit;
                    if (hit) begin
                        for (int k = 0; k < NUM_HARTS; k++) begin
                            if (k != h && v[k] && (g[k] == req_gran_i[h])) v[k] = 1'b0;
                        end
                    end
                    v[h] = 1'b0;
                end
                OP_STORE: begin
                    for (int k = 0; k < NUM_HARTS; k++) begin
                        if (k != h && v[k] && (g[k] == req_gran_i[h])) v[k] = 1'b0;
                    end
                end
                default: ;
            endcase
        end

        vld_o  = v;
        gran_o = g;
    end
endmodule

// File: rtl/rm_resv_monitor.sv
module rm_resv_monitor
    import rm_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int ADDR_W    = 32,
    parameter int GRAN_LG   = 6,
    parameter int HOLD_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [2*NUM_HARTS-1:0]        req_op,
    input  logic [NUM_HARTS*ADDR_W-1:0]   req_addr,
    input  logic                          hold_en,
    input  logic [HOLD_W-1:0]             hold_cycles,
    input  logic                          inval_valid,
    input  logic [ADDR_W-1:0]             inval_addr,
    output logic                          inval_stall,
    output logic [NUM_HARTS-1:0]          resp_valid,
    output logic [NUM_HARTS-1:0]          resp_fail,
    output logic [NUM_HARTS-1:0]          resp_excl
);
    localparam int GRAN_W = ADDR_W - GRAN_LG;

    logic [NUM_HARTS-1:0]             res_vld;
    logic [NUM_HARTS-1:0][GRAN_W-1:0] res_gran;
    logic [NUM_HARTS-1:0]             nxt_vld;
    logic [NUM_HARTS-1:0][GRAN_W-1:0] nxt_gran;
    logic [NUM_HARTS-1:0][1:0]        op_a;
    logic [NUM_HARTS-1:0][GRAN_W-1:0] rq_gran;
    logic [NUM_HARTS-1:0]             lr_set;
    logic [NUM_HARTS-1:0]             busy;
    logic [NUM_HARTS-1:0]             rsp_c;
    logic [NUM_HARTS-1:0]             fail_c;
    logic [NUM_HARTS-1:0]             excl_c;
    logic [GRAN_W-1:0]                inv_gran;
    logic                             inv_take;

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        assign op_a[h]    = req_op[2*h +: 2];
        assign rq_gran[h] = req_addr[h*ADDR_W + GRAN_LG +: GRAN_W];

        rm_hold_timer #(.HOLD_W(HOLD_W)) u_timer (
            .clk      (clk),
            .rst      (rst),
            .load     (lr_set[h]),
            .load_val (hold_cycles),
            .busy     (busy[h])
        );
    end

    assign inv_gran = inval_addr[ADDR_W-1:GRAN_LG];

    rm_inval_gate #(.NUM_HARTS(NUM_HARTS), .GRAN_W(GRAN_W)) u_gate (
        .vld         (res_vld),
        .gran        (res_gran),
        .busy        (busy),
        .hold_en     (hold_en),
        .inval_valid (inval_valid),
        .inval_gran  (inv_gran),
        .stall       (inval_stall),
        .take        (inv_take)
    );

    rm_resv_chain #(.NUM_HARTS(NUM_HARTS), .GRAN_W(GRAN_W)) u_chain (
        .vld_i        (res_vld),
        .gran_i       (res_gran),
        .op_i         (op_a),
        .req_gran_i   (rq_gran),
        .inval_take_i (inv_take),
        .inval_gran_i (inv_gran),
        .vld_o        (nxt_vld),
        .gran_o       (nxt_gran),
        .lr_set_o     (lr_set),
        .rsp_o        (rsp_c),
        .fail_o       (fail_c),
        .excl_o       (excl_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_vld    <= '0;
            res_gran   <= '0;
            resp_valid <= '0;
            resp_fail  <= '0;
            resp_excl  <= '0;
        end else begin
            res_vld    <= nxt_vld;
            res_gran   <= nxt_gran;
            resp_valid <= rsp_c;
            resp_fail  <= fail_c;
            resp_excl  <= excl_c;
        end
    end
endmodule

// File: rtl/rm_resv_monitor_chk.sv
module rm_resv_monitor_chk
    import rm_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int HOLD_W    = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic [2*NUM_HARTS-1:0] req_op,
    input logic                   inval_valid,
    input logic                   inval_stall,
    input logic [NUM_HARTS-1:0]   resp_valid,
    input logic [NUM_HARTS-1:0]   resp_fail,
    input logic [NUM_HARTS-1:0]   resp_excl,
    input logic [NUM_HARTS-1:0]   res_vld
);
    logic [NUM_HARTS-1:0] rsp_mask;
    logic [NUM_HARTS-1:0] sc_mask;
    logic [NUM_HARTS-1:0] st_mask;
    logic                 any_clr;
    logic [HOLD_W:0]      stall_run;

    always_comb begin
        for (int h = 0; h < NUM_HARTS; h++) begin
            sc_mask[h]  = (req_op[2*h +: 2] == OP_SC);
            st_mask[h]  = (req_op[2*h +: 2] == OP_STORE);
            rsp_mask[h] = (req_op[2*h +: 2] == OP_LR) || sc_mask[h];
        end
        any_clr = (|sc_mask) || (|st_mask) || (inval_valid && !inval_stall);
    end

    always_ff @(posedge clk) begin
        if (rst) stall_run <= '0;
        else if (!inval_stall) stall_run <= '0;
        else if (stall_run != '1) stall_run <= stall_run + 1'b1;
    end

    // R12
    reset_idle_chk: assert property (@(posedge clk) rst |=> (resp_valid == '0 && resp_fail == '0 && resp_excl == '0));

    // R12
    resp_latency_chk: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> resp_valid == $past(rsp_mask));

    // R3
    fail_only_sc_chk: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (resp_fail & ~$past(sc_mask)) == '0);

    // R9
    excl_only_lr_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (resp_excl & ($past(sc_mask) | ~$past(rsp_mask))) == '0);

    // R2
    lr_keeps_others_chk: assert property (@(posedge clk) disable iff (rst)
        !any_clr |=> ($past(res_vld) & ~res_vld) == '0);

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_own
        // R6
        sc_clears_own_chk: assert property (@(posedge clk) disable iff (rst) sc_mask[h] |=> !res_vld[h]);
    end

    // R10
    hold_bound_chk: assert property (@(posedge clk) disable iff (rst) stall_run <= {1'b0, {HOLD_W{1'b1}}});
endmodule

bind rm_resv_monitor rm_resv_monitor_chk #(.NUM_HARTS(NUM_HARTS), .HOLD_W(HOLD_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_op      (req_op),
    .inval_valid (inval_valid),
    .inval_stall (inval_stall),
    .resp_valid  (resp_valid),
    .resp_fail   (resp_fail),
    .resp_excl   (resp_excl),
    .res_vld     (res_vld)
);

// File: tb/sim_rm_resv_monitor.sv
module sim_rm_resv_monitor;
    localparam int NH = 4;
    localparam int AW = 32;
    localparam int HW = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [2*NH-1:0] req_op = '0;
    logic [NH*AW-1:0] req_addr = '0;
    logic            hold_en = 1'b0;
    logic [HW-1:0]   hold_cycles = '0;
    logic            inval_valid = 1'b0;
    logic [AW-1:0]   inval_addr = '0;
    logic            inval_stall;
    logic [NH-1:0]   resp_valid, resp_fail, resp_excl;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    rm_resv_monitor u0 (
        .clk(clk), .rst(rst), .req_op(req_op), .req_addr(req_addr),
        .hold_en(hold_en), .hold_cycles(hold_cycles),
        .inval_valid(inval_valid), .inval_addr(inval_addr), .inval_stall(inval_stall),
        .resp_valid(resp_valid), .resp_fail(resp_fail), .resp_excl(resp_excl)
    );

    // Vector: ops (h3..h0, 2 bits each), granules (h3..h0, 4 bits each),
    // expected resp_valid, resp_fail, resp_excl. Ops: 01 LR, 10 SC, 11 store.
    localparam logic [35:0] VEC [0:17] = '{
        {8'b00_00_01_01, 16'h0011, 4'b0011, 4'b0000, 4'b0001}, // R1 R9 second LR sees first
        {8'b00_10_00_00, 16'h0100, 4'b0100, 4'b0100, 4'b0000}, // R3 R5 SC without reservation
        {8'b00_00_10_00, 16'h0010, 4'b0010, 4'b0000, 4'b0000}, // R4 h1 wins, clears h0
        {8'b00_00_00_10, 16'h0001, 4'b0001, 4'b0001, 4'b0000}, // R4 h0 was cleared
        {8'b00_00_01_01, 16'h0032, 4'b0011, 4'b0000, 4'b0011}, // R9 distinct granules
        {8'b00_00_00_01, 16'h0004, 4'b0001, 4'b0000, 4'b0001}, // R1 replace own
        {8'b00_00_00_10, 16'h0002, 4'b0001, 4'b0001, 4'b0000}, // R1 old granule gone
        {8'b00_00_10_00, 16'h0030, 4'b0010, 4'b0000, 4'b0000}, // R2 R3 offset ignored
        {8'b01_01_00_00, 16'h5500, 4'b1100, 4'b0000, 4'b0100}, // R2 R9
        {8'b00_00_00_11, 16'h0005, 4'b0000, 4'b0000, 4'b0000}, // R7 store
        {8'b10_10_00_00, 16'h5500, 4'b1100, 4'b1100, 4'b0000}, // R7 both cleared
        {8'b00_10_01_01, 16'h0666, 4'b0111, 4'b0100, 4'b0001}, // R5 R9
        {8'b00_00_10_10, 16'h0066, 4'b0011, 4'b0010, 4'b0000}, // R8 R4 h0 first
        {8'b00_01_11_01, 16'h0777, 4'b0101, 4'b0000, 4'b0101}, // R8 R7 store between LRs
        {8'b00_10_00_10, 16'h0707, 4'b0101, 4'b0001, 4'b0000}, // R8 R6
        {8'b01_00_00_00, 16'h8000, 4'b1000, 4'b0000, 4'b1000}, // R1
        {8'b11_00_00_00, 16'h8000, 4'b0000, 4'b0000, 4'b0000}, // R7 own kept
        {8'b10_00_00_00, 16'h8000, 4'b1000, 4'b0000, 4'b0000}  // R7 own SC passes
    };

    function automatic logic [AW-1:0] mk_addr(input int g, input int off);
        return (AW'(g) << 6) | AW'(off % 64);
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        req_op = '0;
        req_addr = '0;
    endtask

    task automatic one_req(input int h, input logic [1:0] op, input int g, input int off);
        req_op[2*h +: 2] = op;
        req_addr[h*AW +: AW] = mk_addr(g, off);
    endtask

    task automatic resp_chk(input string req, input logic [3:0] v, input logic [3:0] f, input logic [3:0] e);
        chk(req, {20'd0, resp_valid, resp_fail, resp_excl}, {20'd0, v, f, e});
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int n;
        @(negedge clk);
        step();
        rst = 1'b0;
        // R12 reset state
        #1;
        chk("R12 reset outputs", {28'd0, resp_valid | resp_fail | resp_excl}, 32'd0);
        chk("R12 reset stall", {31'd0, inval_stall}, 32'd0);

        for (int i = 0; i < 18; i++) begin
            idle();
            for (int h = 0; h < NH; h++) begin
                one_req(h, VEC[i][28 + 2*h +: 2], int'(VEC[i][12 + 4*h +: 4]), i*7 + h*13);
            end
            step();
            idle();
            resp_chk($sformatf("R1-9 vector %0d", i), VEC[i][11:8], VEC[i][7:4], VEC[i][3:0]);
        end

        // R10: held invalidation lets the reservation survive to its SC
        hold_en = 1'b1;
        hold_cycles = 8'd3;
        one_req(0, 2'b01, 9, 4);
        step();
        idle();
        inval_valid = 1'b1;
        inval_addr = mk_addr(9, 0);
        #1;
        chk("R10 stall on held granule", {31'd0, inval_stall}, 32'd1);
        step();
        one_req(0, 2'b10, 9, 8);
        #1;
        chk("R10 stall still high", {31'd0, inval_stall}, 32'd1);
        step();
        idle();
        resp_chk("R10 SC passes during hold", 4'b0001, 4'b0000, 4'b0000);
        #1;
        chk("R10 no stall after own SC", {31'd0, inval_stall}, 32'd0);
        inval_valid = 1'b0;
        step();

        // R10: stall lasts exactly hold_cycles, then invalidation clears (R11)
        one_req(1, 2'b01, 10, 0);
        step();
        idle();
        inval_valid = 1'b1;
        inval_addr = mk_addr(10, 33);
        n = 0;
        #1;
        while (inval_stall && n < 20) begin
            n++;
            step();
            #1;
        end
        chk("R10 stall length", n, 32'd3);
        step();
        inval_valid = 1'b0;
        one_req(1, 2'b10, 10, 0);
        step();
        idle();
        resp_chk("R11 SC fails after accepted inval", 4'b0010, 4'b0010, 4'b0000);

        // R10: disabled window never stalls
        hold_en = 1'b0;
        one_req(2, 2'b01, 11, 0);
        step();
        idle();
        inval_valid = 1'b1;
        inval_addr = mk_addr(11, 0);
        #1;
        chk("R10 hold disabled no stall", {31'd0, inval_stall}, 32'd0);
        step();
        inval_valid = 1'b0;
        one_req(2, 2'b10, 11, 0);
        step();
        idle();
        resp_chk("R11 inval cleared reservation", 4'b0100, 4'b0100, 4'b0000);

        // R11: other granule kept, and no stall for it
        hold_en = 1'b1;
        one_req(3, 2'b01, 12, 0);
        step();
        idle();
        inval_valid = 1'b1;
        inval_addr = mk_addr(13, 0);
        #1;
        chk("R10 other granule no stall", {31'd0, inval_stall}, 32'd0);
        step();
        inval_valid = 1'b0;
        one_req(3, 2'b10, 12, 0);
        step();
        idle();
        resp_chk("R11 other granule kept", 4'b1000, 4'b0000, 4'b0000);

        // R11: invalidation applied before same-cycle LR
        hold_en = 1'b0;
        inval_valid = 1'b1;
        inval_addr = mk_addr(14, 0);
        one_req(0, 2'b01, 14, 0);
        step();
        inval_valid = 1'b0;
        idle();
        one_req(0, 2'b10, 14, 0);
        step();
        idle();
        resp_chk("R11 LR after inval survives", 4'b0001, 4'b0000, 4'b0000);

        // R12: reset drops reservations
        one_req(0, 2'b01, 15, 0);
        step();
        idle();
        rst = 1'b1;
        step();
        rst = 1'b0;
        #1;
        chk("R12 outputs after reset", {28'd0, resp_valid}, 32'd0);
        one_req(0, 2'b10, 15, 0);
        step();
        idle();
        resp_chk("R12 reservation dropped", 4'b0001, 4'b0001, 4'b0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule